// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two single-precision binary floating-point words over several clock cycles. Each word holds a sign in bit 31, an 8-bit exponent in bits 30:23 with a bias of 127, and a 23-bit fraction in bits 22:0. A leading 1 is implied above the fraction. A one-cycle `start` pulse captures both operands and the operation bit. The block then works through a fixed sequence of steps:

- It puts the hidden bits back on both significands.
- It aligns the smaller-magnitude operand, keeping a guard, a round and a sticky bit.
- It adds or subtracts the significands in sign-magnitude form.
- It normalizes the sum, one bit position per cycle when the operands cancel.
- It rounds to nearest, ties to even, and renormalizes if rounding carries.
- It packs the result and sets the flags.

When the result is ready, `done` pulses high for one cycle. The result word and the two flags stay unchanged until the next `done`.

Denormal inputs are flushed to zero. An operand whose exponent field is all ones is reported as an overflow. The block is intended as an arithmetic unit under a sequencer that issues one operation at a time.

Top module: `fp_addsub_seq`

## Requirements
- R1: Reset behaviour. While `rst` is high, and after it falls with no operation started, `done`, `result`, `ovf` and `unf` are all 0. A reset during an operation abandons it, and no `done` follows.
- R2: Start is ignored while busy. `start` is only accepted when the block is idle. Pulses that arrive while an operation is running have no effect on that operation's result.
- R3: Operation and sign. With `op`=0 the result is a+b. With `op`=1 the result is a-b, computed as a plus b with b's sign inverted. A nonzero result takes the sign of the larger-magnitude operand. Fields are sign in bit 31, biased exponent in bits 30:23 and fraction in bits 22:0.
- R4: Alignment and rounding. The smaller operand is shifted right by the exponent difference, and guard, round and sticky bits are kept, where sticky is the OR of every bit below round. Rounding adds one unit in the last place when guard=1 and at least one of round, sticky or the kept LSB is 1.
- R5: Carry on a same-sign add. When the effective signs match and the significand sum reaches 2 or more, the sum is shifted right one place and the exponent is incremented.
- R6: Cancellation. When the effective signs differ, the difference is shifted left one place at a time, decrementing the exponent each time, until the leading 1 is in the hidden position.
- R7: Rounding carry. If rounding carries out of the 24-bit significand, the significand is shifted right once and the exponent is incremented before packing.
- R8: Overflow. A final exponent above 254 gives a result with an all-ones exponent, a zero fraction and the result sign, and sets `ovf`=1.
- R9: Underflow. A final exponent below 1 gives the result 0x00000000 and sets `unf`=1.
- R10: Zeros. An operand with exponent field 0 is treated as zero, whatever its fraction. An exact zero result is encoded as +0 (0x00000000) with both flags 0.
- R11: Special operands. If either operand has an all-ones exponent, the result is 0x7F800000 with the sign of that operand (a is checked first, and b's sign is taken after `op` is applied), and `ovf`=1.
- R12: Completion. `done` is a single-cycle pulse. `result`, `ovf` and `unf` change only in the cycle in which `done` is 1 and then hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Capture operands and begin an operation (idle only) |
| op | input | 1 | 0 = add, 1 = subtract b from a |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| done | output | 1 | One-cycle pulse when the result is valid |
| result | output | 32 | Packed result word |
| ovf | output | 1 | Exponent overflow or special operand |
| unf | output | 1 | Exponent underflow, result forced to zero |

## Verification
Two of the block's functions can fall in the same cycle: the carry out of rounding and the overflow check on the exponent it bumps. The bench provokes this by adding half a unit in the last place to the largest finite value. The resulting tie rounds up, the carry pushes the exponent from 254 to 255, and the bench requires the infinity encoding with `ovf` set.

A second coincidence joins subtraction and the sticky bit. Subtracting 2^-30 from 1.0 loses every bit of the small operand into sticky, forces one left shift, and then a rounding carry. That case must return exactly 1.0.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

  // Sequencer states of the multi-cycle adder
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALIGN,
    ST_ADD,
    ST_NORM,
    ST_ROUND,
    ST_RENORM,
    ST_PACK
  } fpa_state_e;

endpackage

// File: rtl/fpa_prep.sv
// Unpacks both operands, applies the subtract flip, flushes exponent-zero
// inputs to zero, and orders the operands by magnitude.
module fpa_prep #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] a,
  input  logic [EXP_W+FRAC_W:0] b,
  input  logic                  sub,
  output logic [FRAC_W:0]       big_sig,
  output logic [FRAC_W:0]       small_sig,
  output logic [EXP_W-1:0]      big_exp,
  output logic [EXP_W-1:0]      exp_diff,
  output logic                  big_sign,
  output logic                  eff_sub,
  output logic                  special,
  output logic                  special_sign
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int MAG_W  = EXP_W + FRAC_W;

  logic [EXP_W-1:0] exp_a, exp_b, small_exp;
  logic             sgn_a, sgn_b;
  logic             zer_a, zer_b, inf_a, inf_b;
  logic [MAG_W-1:0] mag_a, mag_b;
  logic [SIG_W-1:0] sig_a, sig_b;
  logic             a_wins;

  assign exp_a = a[WORD_W-2 -: EXP_W];
  assign exp_b = b[WORD_W-2 -: EXP_W];
  assign sgn_a = a[WORD_W-1];
  assign sgn_b = b[WORD_W-1] ^ sub;

  assign zer_a = (exp_a == '0);
  assign zer_b = (exp_b == '0);
  assign inf_a = (exp_a == '1);
  assign inf_b = (exp_b == '1);

  // Magnitude keys and significands with the hidden bit restored
  assign mag_a = zer_a ? '0 : a[MAG_W-1:0];
  assign mag_b = zer_b ? '0 : b[MAG_W-1:0];
  assign sig_a = zer_a ? '0 : {1'b1, a[FRAC_W-1:0]};
  assign sig_b = zer_b ? '0 : {1'b1, b[FRAC_W-1:0]};

  assign a_wins    = (mag_a >= mag_b);
  assign big_sig   = a_wins ? sig_a : sig_b;
  assign small_sig = a_wins ? sig_b : sig_a;
  assign big_exp   = a_wins ? exp_a : exp_b;
  assign small_exp = a_wins ? exp_b : exp_a;
  assign exp_diff  = big_exp - small_exp;
  assign big_sign  = a_wins ? sgn_a : sgn_b;
  assign eff_sub   = sgn_a ^ sgn_b;

  assign special      = inf_a | inf_b;
  assign special_sign = inf_a ? sgn_a : sgn_b;

endmodule

// File: rtl/fpa_align.sv
// Right-shifts a significand by the exponent difference. The output carries
// guard and round below the significand, and a sticky bit that ORs every
// bit pushed past the round position.
module fpa_align #(
  parameter int SIG_W = 24,
  parameter int AMT_W = 8
) (
  input  logic [SIG_W-1:0] sig,
  input  logic [AMT_W-1:0] amt,
  output logic [SIG_W+2:0] aligned
);
  localparam int EXT_W = SIG_W + 3;

  logic [2*EXT_W-1:0] wide;

  // Upper half is the kept value, lower half collects the lost bits
  assign wide    = {sig, 3'b000, {EXT_W{1'b0}}} >> amt;
  assign aligned = {wide[2*EXT_W-1:EXT_W+1], wide[EXT_W] | (|wide[EXT_W-1:0])};

endmodule

// File: rtl/fpa_round.sv
// Round to nearest, ties to even, on a significand with guard/round/sticky.
module fpa_round #(
  parameter int SIG_W = 24
) (
  input  logic [SIG_W+2:0] mant,
  output logic [SIG_W:0]   rounded
);
  logic keep_lsb, grd, rnd, stk, bump;

  assign keep_lsb = mant[3];
  assign grd      = mant[2];
  assign rnd      = mant[1];
  assign stk      = mant[0];
  assign bump     = grd & (rnd | stk | keep_lsb);
  assign rounded  = {1'b0, mant[SIG_W+2:3]} + {{SIG_W{1'b0}}, bump};

endmodule

// File: rtl/fp_addsub_seq.sv
// Multi-cycle floating-point adder/subtractor, registered outputs.
module fp_addsub_seq
  import fpa_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    op,
  input  logic [EXP_W+FRAC_W:0]   a,
  input  logic [EXP_W+FRAC_W:0]   b,
  output logic                    done,
  output logic [EXP_W+FRAC_W:0]   result,
  output logic                    ovf,
  output logic                    unf
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int GRS_W  = SIG_W + 3;
  localparam int ACC_W  = SIG_W + 4;
  localparam int XW     = EXP_W + 2;
  localparam logic signed [XW-1:0] EXP_HI  = XW'((1 << EXP_W) - 2);
  localparam logic signed [XW-1:0] EXP_LO  = XW'(1);
  localparam logic signed [XW-1:0] EXP_ONE = XW'(1);

  fpa_state_e state_q;

  logic [WORD_W-1:0]    a_q, b_q;
  logic                 op_q;
  logic [ACC_W-1:0]     lhs_q, rhs_q, acc_q;
  logic signed [XW-1:0] exp_q;
  logic                 sign_q, eff_sub_q, special_q, spec_sign_q, zero_q;
  logic [SIG_W:0]       rnd_q;
  logic [FRAC_W-1:0]    frac_q;

  logic [SIG_W-1:0]  big_sig, small_sig;
  logic [EXP_W-1:0]  big_exp, exp_diff;
  logic              big_sign, eff_sub, special, special_sign;
  logic [GRS_W-1:0]  aligned;
  logic [SIG_W:0]    rounded;

  logic [WORD_W-1:0] pack_word;
  logic              pack_ovf, pack_unf;

  fpa_prep #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) prep_i (
    .a            (a_q),
    .b            (b_q),
    .sub          (op_q),
    .big_sig      (big_sig),
    .small_sig    (small_sig),
    .big_exp      (big_exp),
    .exp_diff     (exp_diff),
    .big_sign     (big_sign),
    .eff_sub      (eff_sub),
    .special      (special),
    .special_sign (special_sign)
  );

  fpa_align #(.SIG_W(SIG_W), .AMT_W(EXP_W)) align_i (
    .sig     (small_sig),
    .amt     (exp_diff),
    .aligned (aligned)
  );

  fpa_round #(.SIG_W(SIG_W)) round_i (
    .mant    (acc_q[GRS_W-1:0]),
    .rounded (rounded)
  );

  // Final packing and range checks on the renormalized exponent
  always_comb begin
    pack_ovf  = 1'b0;
    pack_unf  = 1'b0;
    pack_word = {sign_q, exp_q[EXP_W-1:0], frac_q};
    if (special_q) begin
      pack_word = {spec_sign_q, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      pack_ovf  = 1'b1;
    end else if (zero_q) begin
      pack_word = '0;
    end else if (exp_q > EXP_HI) begin
      pack_word = {sign_q, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      pack_ovf  = 1'b1;
    end else if (exp_q < EXP_LO) begin
      pack_word = '0;
      pack_unf  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      done        <= 1'b0;
      result      <= '0;
      ovf         <= 1'b0;
      unf         <= 1'b0;
      a_q         <= '0;
      b_q         <= '0;
      op_q        <= 1'b0;
      lhs_q       <= '0;
      rhs_q       <= '0;
      acc_q       <= '0;
      exp_q       <= '0;
      sign_q      <= 1'b0;
      eff_sub_q   <= 1'b0;
      special_q   <= 1'b0;
      spec_sign_q <= 1'b0;
      zero_q      <= 1'b0;
      rnd_q       <= '0;
      frac_q      <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            a_q     <= a;
            b_q     <= b;
            op_q    <= op;
            state_q <= ST_ALIGN;
          end
        end
        ST_ALIGN: begin
          lhs_q       <= {1'b0, big_sig, 3'b000};
          rhs_q       <= {1'b0, aligned};
          exp_q       <= $signed({2'b00, big_exp});
          sign_q      <= big_sign;
          eff_sub_q   <= eff_sub;
          special_q   <= special;
          spec_sign_q <= special_sign;
          zero_q      <= 1'b0;
          state_q     <= ST_ADD;
        end
        ST_ADD: begin
          acc_q   <= eff_sub_q ? (lhs_q - rhs_q) : (lhs_q + rhs_q);
          state_q <= special_q ? ST_PACK : ST_NORM;
        end
        ST_NORM: begin
          if (acc_q == '0) begin
            zero_q  <= 1'b1;
            state_q <= ST_PACK;
          end else if (acc_q[ACC_W-1]) begin
            acc_q   <= {1'b0, acc_q[ACC_W-1:2], acc_q[1] | acc_q[0]};
            exp_q   <= exp_q + EXP_ONE;
            state_q <= ST_ROUND;
          end else if (!acc_q[ACC_W-2]) begin
            acc_q <= {acc_q[ACC_W-2:0], 1'b0};
            exp_q <= exp_q - EXP_ONE;
          end else begin
            state_q <= ST_ROUND;
          end
        end
        ST_ROUND: begin
          rnd_q   <= rounded;
          state_q <= ST_RENORM;
        end
        ST_RENORM: begin
          if (rnd_q[SIG_W]) begin
            frac_q <= rnd_q[FRAC_W:1];
            exp_q  <= exp_q + EXP_ONE;
          end else begin
            frac_q <= rnd_q[FRAC_W-1:0];
          end
          state_q <= ST_PACK;
        end
        ST_PACK: begin
          done    <= 1'b1;
          result  <= pack_word;
          ovf     <= pack_ovf;
          unf     <= pack_unf;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fp_addsub_chk.sv
// Property checker attached to the adder by bind.
module fp_addsub_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  done,
  input logic [EXP_W+FRAC_W:0] result,
  input logic                  ovf,
  input logic                  unf
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R12
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!done && !$past(rst)) |-> ($stable(result) && $stable(ovf) && $stable(unf)));

  // R8
  ovf_encoding_chk: assert property (@(posedge clk) disable iff (rst)
    (done && ovf) |-> (result[WORD_W-2 -: EXP_W] == '1 && result[FRAC_W-1:0] == '0));

  // R9
  unf_encoding_chk: assert property (@(posedge clk) disable iff (rst)
    (done && unf) |-> (result == '0 && !ovf));

  // R8
  inf_needs_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (done && result[WORD_W-2 -: EXP_W] == '1) |-> ovf);

  // R10
  plus_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done && result[WORD_W-2:0] == '0) |-> !result[WORD_W-1]);

endmodule

bind fp_addsub_seq fp_addsub_chk chk_i (
  .clk    (clk),
  .rst    (rst),
  .done   (done),
  .result (result),
  .ovf    (ovf),
  .unf    (unf)
);

// File: tb/fp_addsub_seq_tb_top.sv
`timescale 1ns/1ps
module fp_addsub_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        op = 1'b0;
  logic [31:0] a = '0;
  logic [31:0] b = '0;
  logic        done;
  logic [31:0] result;
  logic        ovf, unf;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fp_addsub_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .op(op), .a(a), .b(b),
    .done(done), .result(result), .ovf(ovf), .unf(unf)
  );

  typedef struct packed {
    logic [31:0] x;
    logic [31:0] y;
    logic        o;
    logic [31:0] res;
    logic        fo;
    logic        fu;
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000, 1'b0, 1'b0, "R5 "}, // 1+1
    '{32'h3F000000, 32'h3EE00000, 1'b1, 32'h3D800000, 1'b0, 1'b0, "R6 "}, // 0.5-0.4375
    '{32'hBF000000, 32'hBE800000, 1'b0, 32'hBF400000, 1'b0, 1'b0, "R3 "}, // -0.75
    '{32'h3FC00000, 32'h40200000, 1'b0, 32'h40800000, 1'b0, 1'b0, "R5 "}, // 1.5+2.5
    '{32'h40400000, 32'h40A00000, 1'b1, 32'hC0000000, 1'b0, 1'b0, "R3 "}, // 3-5
    '{32'h40490FDB, 32'h40490FDB, 1'b1, 32'h00000000, 1'b0, 1'b0, "R10"}, // x-x
    '{32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, 1'b0, 1'b0, "R4 "}, // tie, even down
    '{32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, 1'b0, 1'b0, "R4 "}, // tie, odd up
    '{32'h3F800000, 32'h33C00000, 1'b0, 32'h3F800001, 1'b0, 1'b0, "R4 "}, // above half
    '{32'h3FFFFFFF, 32'h33800000, 1'b0, 32'h40000000, 1'b0, 1'b0, "R7 "}, // round carry
    '{32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, 1'b1, 1'b0, "R8 "}, // max+max
    '{32'h7F7FFFFF, 32'h73000000, 1'b0, 32'h7F800000, 1'b1, 1'b0, "R8 "}, // round carry -> ovf
    '{32'h00800001, 32'h00800000, 1'b1, 32'h00000000, 1'b0, 1'b1, "R9 "}, // underflow
    '{32'h00000000, 32'h40400000, 1'b0, 32'h40400000, 1'b0, 1'b0, "R10"}, // 0+3
    '{32'h00000123, 32'h3F800000, 1'b0, 32'h3F800000, 1'b0, 1'b0, "R10"}, // denormal flushed
    '{32'h3F800000, 32'h3F7FFFFF, 1'b1, 32'h33800000, 1'b0, 1'b0, "R6 "}, // deep cancel
    '{32'hBF800000, 32'h40400000, 1'b0, 32'h40000000, 1'b0, 1'b0, "R3 "}, // -1+3
    '{32'h3F800000, 32'hBF800000, 1'b1, 32'h40000000, 1'b0, 1'b0, "R3 "}, // 1-(-1)
    '{32'h7F800000, 32'h3F800000, 1'b0, 32'h7F800000, 1'b1, 1'b0, "R11"}, // inf operand
    '{32'h3E800000, 32'h3F800000, 1'b0, 32'h3FA00000, 1'b0, 1'b0, "R3 "}, // small a
    '{32'h3F800000, 32'h30800000, 1'b1, 32'h3F800000, 1'b0, 1'b0, "R7 "}, // sticky + carry
    '{32'h3F800000, 32'hFF800000, 1'b1, 32'h7F800000, 1'b1, 1'b0, "R11"}, // 1-(-inf)
    '{32'hBF800000, 32'h3F800000, 1'b0, 32'h00000000, 1'b0, 1'b0, "R10"}, // -1+1
    '{32'h80000000, 32'h80000000, 1'b0, 32'h00000000, 1'b0, 1'b0, "R10"}  // -0+-0
  };

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] x, input logic [31:0] y, input logic o);
    @(negedge clk);
    a = x; b = y; op = o; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (done !== 1'b1) @(negedge clk);
  endtask

  // Watchdog: a hung run counts as a failure and still reports
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog: actual no completion expected done pulse");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seen;
    logic [33:0] held;

    // R1: outputs cleared while in reset and after release
    repeat (3) @(negedge clk);
    check("R1", "outputs in reset", {done, ovf, unf, result}, '0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", "outputs idle after reset", {done, ovf, unf, result}, '0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      run_op(VECS[i].x, VECS[i].y, VECS[i].o);
      check($sformatf("%s", VECS[i].tag), $sformatf("vector %0d", i),
            {result, ovf, unf}, {VECS[i].res, VECS[i].fo, VECS[i].fu});
      held = {result, ovf, unf};
      @(negedge clk);
      // R12: done lasts one cycle and the outputs hold
      check("R12", "done pulse width", {63'b0, done}, 64'd0);
      check("R12", "outputs held after done", {result, ovf, unf}, held);
    end

    // R2: start pulses while busy must not disturb the running operation
    @(negedge clk);
    a = 32'h3F800000; b = 32'h3F800000; op = 1'b0; start = 1'b1;
    @(negedge clk);
    a = 32'h40400000; b = 32'h40A00000; op = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (done !== 1'b1) @(negedge clk);
    check("R2", "result with start while busy", {result, ovf, unf}, {32'h40000000, 2'b00});
    seen = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (done) seen++;
    end
    check("R2", "no extra completion", 64'(seen), 64'd0);

    // R12: outputs still hold after a long idle stretch
    check("R12", "outputs held while idle", {result, ovf, unf}, {32'h40000000, 2'b00});

    // R1: reset in the middle of an operation
    @(negedge clk);
    a = 32'h3FC00000; b = 32'h40200000; op = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "outputs after mid-op reset", {done, ovf, unf, result}, '0);
    seen = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (done) seen++;
    end
    check("R1", "abandoned op gives no done", 64'(seen), 64'd0);

    // R3 after reset: a fresh operation still completes correctly
    run_op(32'h40400000, 32'h3F800000, 1'b1);
    check("R3", "3-1 after reset", {result, ovf, unf}, {32'h40000000, 2'b00});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule